// File: doc/BRIEF.md
# SDRAM Burst Access Sequencer

This block turns host burst requests into the command sequence of a clocked SDRAM and schedules the data beats of each burst. An accepted request produces a row activate, then one read or write column command. After a fixed column latency, a data strobe marks one beat per cycle. An internal column counter supplies the column of every beat, so no further column command is needed during the burst. Between bursts the block issues periodic auto-refresh commands. The row addresses for refresh come from its own refresh row counter.

The host side is valid/ready. A request is taken in a cycle where `req_valid` and `req_ready` are both high. The host must hold `req_valid` and the request fields steady until then. `req_ready` stays low from acceptance until the cycle after the last beat, and during any pending or active refresh. The beat timing is fixed by the memory, so the data paths cannot apply back-pressure. During a write beat (`wr_ready` high), the host must present the word on `wr_data` in that same cycle. Each read word appears once, with `rd_valid`, and must be taken in that cycle.

Top module: `sdram_burst_seq`

## Requirements
- R1: Out of reset, `req_ready` is 1, the command is deselect, `xfer_strobe` is 0 and `rd_valid` is 0.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n}. Deselect is 1111, activate is 0011, read is 0101, write is 0100 and refresh is 0001.
- R3: The cycle after a request is accepted carries activate with the request row on `sd_addr`. The next cycle carries read or write, chosen by `req_write` (1 = write), with the start column zero-extended on `sd_addr`. Every other cycle of the burst is deselect.
- R4: `xfer_strobe` first rises exactly CAS_LAT cycles after the column command cycle. It then stays high for exactly the burst length, in consecutive cycles.
- R5: The burst length is 4 when `req_long` is 0 and 8 when it is 1, sampled at acceptance.
- R6: `xfer_col` gives the column of each beat. The columns step up by one inside the aligned block of burst-length columns that holds the start column, and wrap to the block's base (start 6 with length 4 gives 6, 7, 4, 5).
- R7: In a read beat, the word on `sd_rdata` is latched. It appears on `rd_data` with `rd_valid` high in the next cycle.
- R8: In a write beat, `wr_ready` is high. The `wr_data` word of that cycle appears on `sd_wdata` with `sd_wdata_en` high in the next cycle.
- R9: `req_ready` is low from acceptance until the cycle after the last beat. No refresh command starts inside a burst.
- R10: Every REF_INT cycles a refresh becomes pending and `req_ready` drops, so the refresh is served before any waiting request. The refresh command carries a refresh row that starts at 0 and counts up by one per refresh, modulo 2^ROW_W.
- R11: A refresh holds the block busy for TRFC cycles from its command cycle. In those cycles `req_ready` is low and every cycle after the first is deselect.
- R12: A refresh leaves `rd_data` unchanged and raises no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_row | input | ROW_W | Row to activate |
| req_col | input | COL_W | Start column |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_long | input | 1 | 1 = 8 beats, 0 = 4 beats |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | Row, column or refresh row (ROW_W >= COL_W) |
| sd_rdata | input | DW | Read data from the memory |
| sd_wdata | output | DW | Write data latch to the memory |
| sd_wdata_en | output | 1 | `sd_wdata` valid this cycle |
| xfer_strobe | output | 1 | Data beat in this cycle |
| xfer_col | output | COL_W | Column of the current beat |
| wr_ready | output | 1 | Host must present write data now |
| wr_data | input | DW | Host write data |
| rd_valid | output | 1 | `rd_data` carries a new read word |
| rd_data | output | DW | Read data latch |

## Verification
Both burst lengths are driven with start columns at the base, in the middle and at the top of an aligned block. This separates correct wrapping from a plain incrementing or saturating column counter. Writes followed by read-back to the same columns catch any beat that samples data one cycle early or late. Requests sent back to back, and held while a refresh comes due, show whether refresh jumps ahead of waiting work, and whether the read latch survives the refresh. Random rows, columns, directions and gaps, with a fixed seed, fill in the remaining timing mixes.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_COL,
    ST_XFER,
    ST_REF
  } seq_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_DESEL = sd_cmd_t'(4'b1111);
  localparam sd_cmd_t CMD_ACT   = sd_cmd_t'(4'b0011);
  localparam sd_cmd_t CMD_READ  = sd_cmd_t'(4'b0101);
  localparam sd_cmd_t CMD_WRITE = sd_cmd_t'(4'b0100);
  localparam sd_cmd_t CMD_REF   = sd_cmd_t'(4'b0001);

endpackage

// File: rtl/sdseq_refresh_timer.sv
module sdseq_refresh_timer #(
  parameter int REF_INT = 780,
  parameter int ROW_W   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             served,
  input  logic             row_adv,
  output logic             pending,
  output logic [ROW_W-1:0] ref_row
);
  localparam int CW = $clog2(REF_INT);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == CW'(REF_INT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
      ref_row <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + CW'(1);
      if (served) pending <= 1'b0;
      if (tick)   pending <= 1'b1;
      if (row_adv) ref_row <= ref_row + ROW_W'(1);
    end
  end
endmodule

// File: rtl/sdseq_col_counter.sv
module sdseq_col_counter #(
  parameter int COL_W    = 9,
  parameter int BL_SHORT = 4,
  parameter int BL_LONG  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] start_col,
  input  logic             long_sel,
  input  logic             step,
  output logic [COL_W-1:0] col
);
  localparam logic [COL_W-1:0] MASK_S = COL_W'(BL_SHORT - 1);
  localparam logic [COL_W-1:0] MASK_L = COL_W'(BL_LONG - 1);

  logic [COL_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col    <= '0;
      mask_q <= MASK_S;
    end else if (load) begin
      col    <= start_col;
      mask_q <= long_sel ? MASK_L : MASK_S;
    end else if (step) begin
      col <= (col & ~mask_q) | ((col + COL_W'(1)) & mask_q);
    end
  end
endmodule

// File: rtl/sdseq_datapath.sv
module sdseq_datapath #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_beat,
  input  logic          wr_beat,
  input  logic [DW-1:0] sd_rdata,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          sd_wdata_en,
  output logic [DW-1:0] sd_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      sd_wdata_en <= 1'b0;
      sd_wdata    <= '0;
    end else begin
      rd_valid    <= rd_beat;
      sd_wdata_en <= wr_beat;
      if (rd_beat) rd_data  <= sd_rdata;
      if (wr_beat) sd_wdata <= wr_data;
    end
  end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdseq_pkg::*;
#(
  parameter int ROW_W    = 13,
  parameter int COL_W    = 9,
  parameter int DW       = 16,
  parameter int CAS_LAT  = 4,
  parameter int BL_SHORT = 4,
  parameter int BL_LONG  = 8,
  parameter int REF_INT  = 780,
  parameter int TRFC     = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_write,
  input  logic             req_long,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic [ROW_W-1:0] sd_addr,
  input  logic [DW-1:0]    sd_rdata,
  output logic [DW-1:0]    sd_wdata,
  output logic             sd_wdata_en,
  output logic             xfer_strobe,
  output logic [COL_W-1:0] xfer_col,
  output logic             wr_ready,
  input  logic [DW-1:0]    wr_data,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data
);
  localparam int TW = $clog2(CAS_LAT + BL_LONG + TRFC + 1);

  seq_state_e       st;
  logic [TW-1:0]    tcnt;
  logic [TW-1:0]    last_t;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic             long_q;
  logic             accept;
  logic             beat;
  logic             ref_pend;
  logic             ref_take;
  logic             ref_adv;
  logic [ROW_W-1:0] ref_row;
  sd_cmd_t          cmd;

  assign req_ready = (st == ST_IDLE) && !ref_pend;
  assign accept    = req_valid && req_ready;
  assign ref_take  = (st == ST_IDLE) && ref_pend;
  assign ref_adv   = (st == ST_REF) && (tcnt == '0);
  assign last_t    = TW'(CAS_LAT) + (long_q ? TW'(BL_LONG) : TW'(BL_SHORT)) - TW'(1);
  assign beat      = (st == ST_XFER) && (tcnt >= TW'(CAS_LAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      tcnt   <= '0;
      row_q  <= '0;
      col_q  <= '0;
      wr_q   <= 1'b0;
      long_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          tcnt <= '0;
          if (ref_pend) begin
            st <= ST_REF;
          end else if (accept) begin
            st     <= ST_ACT;
            row_q  <= req_row;
            col_q  <= req_col;
            wr_q   <= req_write;
            long_q <= req_long;
          end
        end
        ST_ACT: st <= ST_COL;
        ST_COL: begin
          st   <= ST_XFER;
          tcnt <= TW'(1);
        end
        ST_XFER: begin
          if (tcnt == last_t) st <= ST_IDLE;
          else                tcnt <= tcnt + TW'(1);
        end
        ST_REF: begin
          if (tcnt == TW'(TRFC - 1)) st <= ST_IDLE;
          else                       tcnt <= tcnt + TW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd     = CMD_DESEL;
    sd_addr = '0;
    case (st)
      ST_ACT: begin
        cmd     = CMD_ACT;
        sd_addr = row_q;
      end
      ST_COL: begin
        cmd     = wr_q ? CMD_WRITE : CMD_READ;
        sd_addr = ROW_W'(col_q);
      end
      ST_REF: begin
        if (tcnt == '0) begin
          cmd     = CMD_REF;
          sd_addr = ref_row;
        end
      end
      default: ;
    endcase
  end

  assign sd_cs_n     = cmd.cs_n;
  assign sd_ras_n    = cmd.ras_n;
  assign sd_cas_n    = cmd.cas_n;
  assign sd_we_n     = cmd.we_n;
  assign xfer_strobe = beat;
  assign wr_ready    = beat && wr_q;

  sdseq_refresh_timer #(.REF_INT(REF_INT), .ROW_W(ROW_W)) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .served  (ref_take),
    .row_adv (ref_adv),
    .pending (ref_pend),
    .ref_row (ref_row)
  );

  sdseq_col_counter #(.COL_W(COL_W), .BL_SHORT(BL_SHORT), .BL_LONG(BL_LONG)) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .start_col (req_col),
    .long_sel  (req_long),
    .step      (beat),
    .col       (xfer_col)
  );

  sdseq_datapath #(.DW(DW)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_beat     (beat && !wr_q),
    .wr_beat     (beat && wr_q),
    .sd_rdata    (sd_rdata),
    .wr_data     (wr_data),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .sd_wdata_en (sd_wdata_en),
    .sd_wdata    (sd_wdata)
  );
endmodule

// File: rtl/sdseq_chk.sv
module sdseq_chk #(
  parameter int COL_W   = 9,
  parameter int DW      = 16,
  parameter int BL_LONG = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             sd_cs_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic             xfer_strobe,
  input logic [COL_W-1:0] xfer_col,
  input logic             wr_ready,
  input logic [DW-1:0]    wr_data,
  input logic [DW-1:0]    sd_wdata,
  input logic             sd_wdata_en,
  input logic             rd_valid,
  input logic [DW-1:0]    rd_data
);
  localparam int SH = $clog2(BL_LONG);

  logic is_ref;
  assign is_ref = !sd_cs_n && !sd_ras_n && !sd_cas_n && sd_we_n;

  // R3
  accept_then_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!sd_cs_n && !sd_ras_n && sd_cas_n && sd_we_n));

  // R9
  busy_during_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_strobe |-> !req_ready);

  // R6
  col_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_strobe && $past(xfer_strobe)) |-> ((xfer_col >> SH) == ($past(xfer_col) >> SH)));

  // R7
  read_follows_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_strobe && !wr_ready) |=> rd_valid);

  // R8
  write_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> (sd_wdata_en && sd_wdata == $past(wr_data)));

  // R11
  ref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (!xfer_strobe && !req_ready));

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));
endmodule

bind sdram_burst_seq sdseq_chk #(.COL_W(COL_W), .DW(DW), .BL_LONG(BL_LONG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .sd_cs_n     (sd_cs_n),
  .sd_ras_n    (sd_ras_n),
  .sd_cas_n    (sd_cas_n),
  .sd_we_n     (sd_we_n),
  .xfer_strobe (xfer_strobe),
  .xfer_col    (xfer_col),
  .wr_ready    (wr_ready),
  .wr_data     (wr_data),
  .sd_wdata    (sd_wdata),
  .sd_wdata_en (sd_wdata_en),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data)
);

// File: tb/sim_sdram_burst_seq.sv
`timescale 1ns/1ps
module sim_sdram_burst_seq;
  localparam int ROW_W = 5;
  localparam int COL_W = 5;
  localparam int DW    = 16;
  localparam int LAT   = 4;
  localparam int RINT  = 150;
  localparam int TRFC  = 6;
  localparam int ROWS  = 1 << ROW_W;
  localparam int COLS  = 1 << COL_W;
  localparam int DEPTH = ROWS * COLS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_long = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] sd_rdata;
  logic req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [ROW_W-1:0] sd_addr;
  logic [DW-1:0] sd_wdata, rd_data;
  logic sd_wdata_en, xfer_strobe, wr_ready, rd_valid;
  logic [COL_W-1:0] xfer_col;

  always #2 clk = ~clk;

  sdram_burst_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .CAS_LAT(LAT),
                    .REF_INT(RINT), .TRFC(TRFC)) u0 (.*);

  int total = 0, fails = 0, cyc = 0, ref_seen = 0;
  bit done = 1'b0;
  int cur_blen = 4;
  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] mem    [DEPTH];

  function automatic int colk(int start, int k, int blen);
    return (start - (start % blen)) + ((start + k) % blen);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc++;

  // Behavioural memory with its own column counter
  int m_row = 0, m_col = 0, m_cyc = 0;
  bit m_wr = 1'b0;
  always @(posedge clk) begin
    if (m_cyc != 0 && m_cyc < 1000) m_cyc <= m_cyc + 1;
    if (!sd_cs_n && !sd_ras_n && sd_cas_n) m_row <= int'(sd_addr);
    if (!sd_cs_n && sd_ras_n && !sd_cas_n) begin
      m_col <= int'(sd_addr) % COLS;
      m_wr  <= !sd_we_n;
      m_cyc <= 1;
    end
    if (sd_wdata_en)
      mem[m_row*COLS + colk(m_col, m_cyc-LAT-1, cur_blen)] <= sd_wdata;
  end
  always_comb begin
    if (!m_wr && m_cyc >= LAT && m_cyc < LAT + cur_blen)
      sd_rdata = mem[m_row*COLS + colk(m_col, m_cyc-LAT, cur_blen)];
    else
      sd_rdata = 16'hBAD0;
  end

  // Refresh monitor
  int ref_left = 0, exp_row = 0;
  bit hold_chk = 1'b0, prev_ready = 1'b1;
  logic [DW-1:0] snap = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ref_left > 0) begin
        chk("R11 ready low in refresh", req_ready, 0);
        chk("R11 deselect in refresh", {sd_cs_n,sd_ras_n,sd_cas_n,sd_we_n}, 4'b1111);
        chk("R12 no rd_valid in refresh", rd_valid, 0);
        ref_left--;
        if (ref_left == 0) hold_chk = 1'b1;
      end else if (hold_chk) begin
        chk("R12 rd_data kept over refresh", rd_data, snap);
        hold_chk = 1'b0;
      end
      if ({sd_cs_n,sd_ras_n,sd_cas_n,sd_we_n} == 4'b0001) begin
        chk("R10 refresh row", sd_addr, exp_row);
        chk("R10 ready low before refresh", prev_ready, 0);
        chk("R11 ready low at refresh", req_ready, 0);
        snap = rd_data;
        ref_left = TRFC - 1;
        exp_row = (exp_row + 1) % ROWS;
        ref_seen++;
      end
      prev_ready = req_ready;
    end
  end

  task automatic burst(int row, int col, bit wr, bit lng);
    int blen = lng ? 8 : 4;
    int last = 2 + LAT + blen;
    @(negedge clk);
    while (ref_left > 0 || hold_chk) @(negedge clk);
    cur_blen = blen;
    req_row = ROW_W'(row); req_col = COL_W'(col);
    req_write = wr; req_long = lng; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    for (int idx = 1; idx <= last; idx++) begin
      int k = idx - (2 + LAT);
      bit sb = (k >= 0 && k < blen);
      bit pb = (k - 1 >= 0 && k - 1 < blen);
      @(negedge clk);
      if (idx == 1) req_valid = 1'b0;
      if (idx == 1) begin
        chk("R3 activate cmd", {sd_cs_n,sd_ras_n,sd_cas_n,sd_we_n}, 4'b0011);
        chk("R3 activate row", sd_addr, row);
      end else if (idx == 2) begin
        chk("R2 column cmd", {sd_cs_n,sd_ras_n,sd_cas_n,sd_we_n}, wr ? 4'b0100 : 4'b0101);
        chk("R3 start column", sd_addr, col);
      end else begin
        chk("R9 deselect in burst", {sd_cs_n,sd_ras_n,sd_cas_n,sd_we_n}, 4'b1111);
      end
      if (idx < last) chk("R9 ready low in burst", req_ready, 0);
      chk(lng ? "R4 R5 strobe window len8" : "R4 R5 strobe window len4", xfer_strobe, sb);
      chk("R8 wr_ready", wr_ready, sb && wr);
      if (sb) begin
        chk("R6 beat column", xfer_col, colk(col, k, blen));
        if (wr) begin
          wr_data = DW'($urandom);
          shadow[row*COLS + colk(col, k, blen)] = wr_data;
        end
      end
      chk("R7 rd_valid", rd_valid, pb && !wr);
      chk("R8 sd_wdata_en", sd_wdata_en, pb && wr);
      if (pb && !wr) chk("R7 read word", rd_data, shadow[row*COLS + colk(col, k-1, blen)]);
      if (pb && wr) chk("R8 write word", sd_wdata, shadow[row*COLS + colk(col, k-1, blen)]);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    int start_cyc;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) begin
      shadow[i] = DW'(i * 37 + 5);
      mem[i]    = DW'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 deselect after reset", {sd_cs_n,sd_ras_n,sd_cas_n,sd_we_n}, 4'b1111);
    chk("R1 no strobe after reset", xfer_strobe, 0);
    chk("R1 no rd_valid after reset", rd_valid, 0);

    // Directed corners: wrap inside aligned blocks
    burst(3, 6, 1, 0);   burst(3, 6, 0, 0);
    burst(5, 13, 1, 1);  burst(5, 13, 0, 1);
    burst(7, 0, 0, 0);   burst(9, 31, 0, 1);
    burst(9, 28, 1, 0);  burst(9, 24, 0, 1);

    // Random mix, including back-to-back requests
    start_cyc = cyc;
    for (int n = 0; n < 70; n++) begin
      int gap = int'($urandom_range(0, 3));
      burst(int'($urandom_range(0, ROWS-1)), int'($urandom_range(0, COLS-1)),
            1'($urandom), 1'($urandom));
      if (gap == 3) repeat (int'($urandom_range(1, 20))) @(negedge clk);
    end
    // R10: refresh is not starved by continuous requests
    total++;
    if (ref_seen < (cyc - start_cyc) / RINT - 1) begin
      fails++;
      $display("FAIL R10 refresh count: actual %0d expected >= %0d",
               ref_seen, (cyc - start_cyc) / RINT - 1);
    end
    repeat (TRFC + 2) @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule